// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Debug Freeze

This block buffers audio samples in both directions between a serial audio port and a processor bus. Words captured by a receive shifter go into a receive queue, and the processor drains that queue through a read strobe. The processor fills a transmit queue through a write strobe. A transmit serializer pulls words from that queue into a holding word whenever it asks for the next sample. Each queue has its own occupancy flags and a sticky error flag.

A debug hold input arrives from a foreign clock domain and passes through a synchronizer chain in the audio clock domain. While the synchronized hold is active, a debugger may read and write through the normal strobes without changing anything. The queue contents, the pointers, the holding word and all eight flags stay exactly as they were. Normal operation resumes from that preserved state once the hold is released.

Top module: `audio_fifo_freeze`

## Requirements
- R1: After reset both queues are empty. The flags read rxEmpty=1, txEmpty=1 and txAlmostEmpty=1, and every other flag reads 0. txWord is 0 and frozen is 0.
- R2: Received words leave the receive queue in arrival order. busRdData always shows the oldest stored word. A busRdStrobe with the queue not empty and not frozen removes that word at the next clock edge.
- R3: Receive flags follow the stored count n (depth 8): rxEmpty when n=0, rxFull when n=8, rxAlmostFull when n>=6.
- R4: A sample offered by rxValid while the receive queue holds 8 words, outside the hold, is dropped and sets the sticky rxOverrun. rxOvrClr=1 clears rxOverrun. If a new overrun happens in the same cycle, the set wins.
- R5: On txLoadReq outside the hold with the transmit queue not empty, the oldest word moves into txWord. Words leave in write order. A busWrStrobe while the transmit queue holds 8 words is discarded.
- R6: Transmit flags follow the stored count m (depth 8): txEmpty when m=0, txFull when m=8, txAlmostEmpty when m<=2.
- R7: On txLoadReq outside the hold with the transmit queue empty, txWord becomes 0 and the sticky txUnderrun is set. txUndClr=1 clears txUnderrun, and a new underrun in the same cycle wins.
- R8: freezeAsync passes through two flip-flops. frozen rises within 3 audio clock edges of freezeAsync going high, and it drops the same way after freezeAsync goes low.
- R9: While frozen=1, rxValid stores nothing and busRdStrobe removes nothing. busRdData keeps showing the same head word. rxOverrun, rxEmpty, rxFull and rxAlmostFull keep their values, and rxOvrClr is ignored.
- R10: While frozen=1, busWrStrobe is discarded and txLoadReq leaves txWord unchanged. txUnderrun, txFull, txEmpty and txAlmostEmpty keep their values, and txUndClr is ignored.
- R11: After frozen falls, both queues hold the same words in the same order as before the hold, and normal operation resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freezeAsync | input | 1 | Debug hold request from a foreign clock domain |
| rxValid | input | 1 | Receive shifter offers a word this cycle |
| rxSample | input | 16 | Word from the receive shifter |
| busRdStrobe | input | 1 | Bus read of the receive queue |
| busRdData | output | 16 | Oldest word in the receive queue |
| busWrStrobe | input | 1 | Bus write to the transmit queue |
| busWrData | input | 16 | Word written by the bus |
| txLoadReq | input | 1 | Serializer requests the next word |
| txWord | output | 16 | Word held for the transmit serializer |
| rxOvrClr | input | 1 | Write-one-to-clear for rxOverrun |
| txUndClr | input | 1 | Write-one-to-clear for txUnderrun |
| frozen | output | 1 | Synchronized hold state |
| rxOverrun | output | 1 | Sticky receive overrun |
| rxEmpty | output | 1 | Receive queue empty |
| rxFull | output | 1 | Receive queue full |
| rxAlmostFull | output | 1 | Receive queue holds 6 or more words |
| txUnderrun | output | 1 | Sticky transmit underrun |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| txAlmostEmpty | output | 1 | Transmit queue holds 2 or fewer words |

## Verification
A pointer or count that drifts shows up as a wrong flag on the very next edge. A wrong busRdData shows up when the next read is due, and a misordered or missing word in txWord shows up at the next load request. Any update that slips through during the hold changes a flag, busRdData or txWord one edge after the offending strobe. The bench compares these values every cycle of every hold phase. Lost or reordered contents also surface after release, when both queues are drained word by word against the expected order.

// File: rtl/afp_pkg.sv
package afp_pkg;
  // Strobes from control to datapath, already qualified by the hold state.
  typedef struct packed {
    logic rxPush;   // store rxSample at the receive write slot
    logic txPush;   // store busWrData at the transmit write slot
    logic txPop;    // move the transmit head into txWord
    logic txZero;   // load zero into txWord (underrun)
  } afpStb_t;
endpackage

// File: rtl/afp_ptrs.sv
module afp_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  output logic [$clog2(DEPTH)-1:0]   wrIdx,
  output logic [$clog2(DEPTH)-1:0]   rdIdx,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wrNext, rdNext;

  always_comb begin
    wrNext = (wrIdx == LAST) ? '0 : wrIdx + 1'b1;
    rdNext = (rdIdx == LAST) ? '0 : rdIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (push) wrIdx <= wrNext;
      if (pop)  rdIdx <= rdNext;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/afp_ctrl.sv
module afp_ctrl
  import afp_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int AF_LEVEL    = 6,
  parameter int AE_LEVEL    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     freezeAsync,
  input  logic                     rxValid,
  input  logic                     busRdStrobe,
  input  logic                     busWrStrobe,
  input  logic                     txLoadReq,
  input  logic                     rxOvrClr,
  input  logic                     txUndClr,
  output afpStb_t                  stb,
  output logic [$clog2(DEPTH)-1:0] rxWrIdx,
  output logic [$clog2(DEPTH)-1:0] rxRdIdx,
  output logic [$clog2(DEPTH)-1:0] txWrIdx,
  output logic [$clog2(DEPTH)-1:0] txRdIdx,
  output logic                     frozen,
  output logic                     rxOverrun,
  output logic                     rxEmpty,
  output logic                     rxFull,
  output logic                     rxAlmostFull,
  output logic                     txUnderrun,
  output logic                     txFull,
  output logic                     txEmpty,
  output logic                     txAlmostEmpty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
  localparam logic [CW-1:0] AF_N   = CW'(AF_LEVEL);
  localparam logic [CW-1:0] AE_N   = CW'(AE_LEVEL);

  // Hold-request synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncQ[gs] <= 1'b0;
          else        syncQ[gs] <= freezeAsync;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) syncQ[gs] <= 1'b0;
          else        syncQ[gs] <= syncQ[gs-1];
        end
      end
    end
  endgenerate
  assign frozen = syncQ[SYNC_STAGES-1];

  logic [CW-1:0] rxCount, txCount;
  logic rxPop, rxAtFull, rxAtEmpty, txAtFull, txAtEmpty;
  logic rxDrop, txStarve;

  always_comb begin
    rxAtFull  = (rxCount == FULL_N);
    rxAtEmpty = (rxCount == '0);
    txAtFull  = (txCount == FULL_N);
    txAtEmpty = (txCount == '0);

    rxDrop      = rxValid && !frozen && rxAtFull;
    stb.rxPush  = rxValid && !frozen && !rxAtFull;
    rxPop       = busRdStrobe && !frozen && !rxAtEmpty;

    stb.txPush  = busWrStrobe && !frozen && !txAtFull;
    stb.txPop   = txLoadReq && !frozen && !txAtEmpty;
    txStarve    = txLoadReq && !frozen && txAtEmpty;
    stb.txZero  = txStarve;
  end

  afp_ptrs #(.DEPTH(DEPTH)) u_rxPtrs (
    .clk(clk), .rst_n(rst_n), .push(stb.rxPush), .pop(rxPop),
    .wrIdx(rxWrIdx), .rdIdx(rxRdIdx), .count(rxCount)
  );

  afp_ptrs #(.DEPTH(DEPTH)) u_txPtrs (
    .clk(clk), .rst_n(rst_n), .push(stb.txPush), .pop(stb.txPop),
    .wrIdx(txWrIdx), .rdIdx(txRdIdx), .count(txCount)
  );

  // Sticky error flags; a fresh error wins over a clear, and the hold blocks both.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxOverrun  <= 1'b0;
      txUnderrun <= 1'b0;
    end else if (!frozen) begin
      if (rxDrop)        rxOverrun <= 1'b1;
      else if (rxOvrClr) rxOverrun <= 1'b0;
      if (txStarve)      txUnderrun <= 1'b1;
      else if (txUndClr) txUnderrun <= 1'b0;
    end
  end

  always_comb begin
    rxEmpty       = rxAtEmpty;
    rxFull        = rxAtFull;
    rxAlmostFull  = (rxCount >= AF_N);
    txEmpty       = txAtEmpty;
    txFull        = txAtFull;
    txAlmostEmpty = (txCount <= AE_N);
  end
endmodule

// File: rtl/afp_data.sv
module afp_data
  import afp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  afpStb_t                  stb,
  input  logic [$clog2(DEPTH)-1:0] rxWrIdx,
  input  logic [$clog2(DEPTH)-1:0] rxRdIdx,
  input  logic [$clog2(DEPTH)-1:0] txWrIdx,
  input  logic [$clog2(DEPTH)-1:0] txRdIdx,
  input  logic [WIDTH-1:0]         rxSample,
  input  logic [WIDTH-1:0]         busWrData,
  output logic [WIDTH-1:0]         busRdData,
  output logic [WIDTH-1:0]         txWord
);
  logic [WIDTH-1:0] rxMem [DEPTH];
  logic [WIDTH-1:0] txMem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.rxPush) rxMem[rxWrIdx] <= rxSample;
    if (stb.txPush) txMem[txWrIdx] <= busWrData;
  end

  assign busRdData = rxMem[rxRdIdx];

  always_ff @(posedge clk) begin
    if (!rst_n)          txWord <= '0;
    else if (stb.txPop)  txWord <= txMem[txRdIdx];
    else if (stb.txZero) txWord <= '0;
  end
endmodule

// File: rtl/audio_fifo_freeze.sv
module audio_fifo_freeze
  import afp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DEPTH       = 8,
  parameter int AF_LEVEL    = 6,
  parameter int AE_LEVEL    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freezeAsync,
  input  logic             rxValid,
  input  logic [WIDTH-1:0] rxSample,
  input  logic             busRdStrobe,
  output logic [WIDTH-1:0] busRdData,
  input  logic             busWrStrobe,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             txLoadReq,
  output logic [WIDTH-1:0] txWord,
  input  logic             rxOvrClr,
  input  logic             txUndClr,
  output logic             frozen,
  output logic             rxOverrun,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic             rxAlmostFull,
  output logic             txUnderrun,
  output logic             txFull,
  output logic             txEmpty,
  output logic             txAlmostEmpty
);
  localparam int PW = $clog2(DEPTH);

  afpStb_t stb;
  logic [PW-1:0] rxWrIdx, rxRdIdx, txWrIdx, txRdIdx;

  afp_ctrl #(
    .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .freezeAsync(freezeAsync),
    .rxValid(rxValid), .busRdStrobe(busRdStrobe), .busWrStrobe(busWrStrobe),
    .txLoadReq(txLoadReq), .rxOvrClr(rxOvrClr), .txUndClr(txUndClr),
    .stb(stb), .rxWrIdx(rxWrIdx), .rxRdIdx(rxRdIdx), .txWrIdx(txWrIdx), .txRdIdx(txRdIdx),
    .frozen(frozen), .rxOverrun(rxOverrun), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .rxAlmostFull(rxAlmostFull), .txUnderrun(txUnderrun), .txFull(txFull),
    .txEmpty(txEmpty), .txAlmostEmpty(txAlmostEmpty)
  );

  afp_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .rxWrIdx(rxWrIdx), .rxRdIdx(rxRdIdx), .txWrIdx(txWrIdx), .txRdIdx(txRdIdx),
    .rxSample(rxSample), .busWrData(busWrData),
    .busRdData(busRdData), .txWord(txWord)
  );
endmodule

// File: rtl/afp_chk.sv
module afp_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freezeAsync,
  input logic             rxValid,
  input logic [WIDTH-1:0] rxSample,
  input logic             busRdStrobe,
  input logic [WIDTH-1:0] busRdData,
  input logic             busWrStrobe,
  input logic [WIDTH-1:0] busWrData,
  input logic             txLoadReq,
  input logic [WIDTH-1:0] txWord,
  input logic             rxOvrClr,
  input logic             txUndClr,
  input logic             frozen,
  input logic             rxOverrun,
  input logic             rxEmpty,
  input logic             rxFull,
  input logic             rxAlmostFull,
  input logic             txUnderrun,
  input logic             txFull,
  input logic             txEmpty,
  input logic             txAlmostEmpty
);
  a_r3_full_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
    rxFull |-> (rxAlmostFull && !rxEmpty));

  a_r6_empty_implies_ae: assert property (@(posedge clk) disable iff (!rst_n)
    txEmpty |-> (txAlmostEmpty && !txFull));

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && rxValid && rxFull) |=> rxOverrun);

  a_r7_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && txLoadReq && txEmpty) |=> (txUnderrun && txWord == '0));

  a_r8_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(freezeAsync));

  a_r9_rx_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable({rxOverrun, rxEmpty, rxFull, rxAlmostFull}));

  a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rxEmpty) |=> $stable(busRdData));

  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable({txUnderrun, txFull, txEmpty, txAlmostEmpty, txWord}));
endmodule

bind audio_fifo_freeze afp_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_audio_fifo_freeze.sv
`timescale 1ns/1ps
module sim_audio_fifo_freeze;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, freezeAsync, rxValid, busRdStrobe, busWrStrobe, txLoadReq, rxOvrClr, txUndClr;
  logic [15:0] rxSample, busWrData, busRdData, txWord;
  logic frozen, rxOverrun, rxEmpty, rxFull, rxAlmostFull;
  logic txUnderrun, txFull, txEmpty, txAlmostEmpty;

  audio_fifo_freeze u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [15:0] rxQ[$];
  logic [15:0] txQ[$];
  bit mOvr = 0, mUnd = 0;
  logic [15:0] mWord = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doCycle(bit v, logic [15:0] s, bit rd, bit wr, logic [15:0] wd,
                         bit ld, bit oc, bit uc);
    int rc, tc;
    bit f;
    rxValid = v; rxSample = s; busRdStrobe = rd; busWrStrobe = wr; busWrData = wd;
    txLoadReq = ld; rxOvrClr = oc; txUndClr = uc;
    f = frozen;
    rc = rxQ.size();
    tc = txQ.size();
    if (!f) begin
      if (rd && rc != 0) void'(rxQ.pop_front());
      if (v && rc < 8) rxQ.push_back(s);
      if (v && rc == 8) mOvr = 1;
      else if (oc) mOvr = 0;
      if (ld && tc != 0) mWord = txQ.pop_front();
      if (ld && tc == 0) begin mWord = '0; mUnd = 1; end
      else if (uc) mUnd = 0;
      if (wr && tc < 8) txQ.push_back(wd);
    end
    tick();
    rxValid = 0; busRdStrobe = 0; busWrStrobe = 0; txLoadReq = 0; rxOvrClr = 0; txUndClr = 0;
  endtask

  task automatic checkAll(string ctx);
    int n, m;
    n = rxQ.size();
    m = txQ.size();
    chk({"R3 rxEmpty ", ctx},      rxEmpty,      n == 0);
    chk({"R3 rxFull ", ctx},       rxFull,       n == 8);
    chk({"R3 rxAlmostFull ", ctx}, rxAlmostFull, n >= 6);
    chk({"R4 rxOverrun ", ctx},    rxOverrun,    mOvr);
    chk({"R6 txEmpty ", ctx},      txEmpty,      m == 0);
    chk({"R6 txFull ", ctx},       txFull,       m == 8);
    chk({"R6 txAlmostEmpty ", ctx}, txAlmostEmpty, m <= 2);
    chk({"R7 txUnderrun ", ctx},   txUnderrun,   mUnd);
    chk({"R5 txWord ", ctx},       txWord,       mWord);
    if (n != 0) chk({"R2 head ", ctx}, busRdData, rxQ[0]);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 0; freezeAsync = 0; rxValid = 0; rxSample = 0; busRdStrobe = 0;
    busWrStrobe = 0; busWrData = 0; txLoadReq = 0; rxOvrClr = 0; txUndClr = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    chk("R1 rx flags", {rxOverrun, rxEmpty, rxFull, rxAlmostFull}, 4'b0100);
    chk("R1 tx flags", {txUnderrun, txFull, txEmpty, txAlmostEmpty}, 4'b0011);
    chk("R1 txWord", txWord, 16'h0);
    chk("R1 frozen", frozen, 1'b0);

    // Receive fill sweep through every count, then overrun (R2 R3 R4)
    for (int i = 0; i < 10; i++) begin
      doCycle(1, 16'hA000 + 16'(i * 37), 0, 0, 0, 0, 0, 0);
      checkAll("rx fill");
    end
    // Overrun and clear together: set wins
    doCycle(1, 16'h5555, 0, 0, 0, 0, 1, 0);
    checkAll("rx set-wins");
    doCycle(0, 0, 0, 0, 0, 0, 1, 0);
    checkAll("rx clear");
    for (int i = 0; i < 9; i++) begin
      doCycle(0, 0, 1, 0, 0, 0, 0, 0);
      checkAll("rx drain");
    end
    // Mixed push/pop pattern
    for (int i = 0; i < 40; i++) begin
      doCycle((i % 3) != 2, 16'(i * 911 + 7), (i % 4) == 1, 0, 0, 0, (i % 7) == 0, 0);
      checkAll("rx mix");
    end
    while (rxQ.size() != 0) begin doCycle(0, 0, 1, 0, 0, 0, 1, 0); checkAll("rx empty out"); end

    // Transmit fill sweep, discard on full, drain, underrun (R5 R6 R7)
    for (int i = 0; i < 10; i++) begin
      doCycle(0, 0, 0, 1, 16'hB000 + 16'(i * 53), 0, 0, 0);
      checkAll("tx fill");
    end
    for (int i = 0; i < 10; i++) begin
      doCycle(0, 0, 0, 0, 0, 1, 0, 0);
      checkAll("tx drain");
    end
    doCycle(0, 0, 0, 0, 0, 1, 0, 1);
    checkAll("tx set-wins");
    doCycle(0, 0, 0, 0, 0, 0, 0, 1);
    checkAll("tx clear");
    for (int i = 0; i < 40; i++) begin
      doCycle(0, 0, 0, (i % 3) != 1, 16'(i * 613 + 3), (i % 4) == 2, 0, (i % 5) == 0);
      checkAll("tx mix");
    end
    while (txQ.size() != 0) begin doCycle(0, 0, 0, 0, 0, 1, 0, 1); checkAll("tx empty out"); end
    doCycle(0, 0, 0, 0, 0, 0, 1, 1);
    checkAll("flags clear");

    // Hold phases with varied fill levels and start phases (R8 R9 R10 R11)
    for (int ph = 0; ph < 8; ph++) begin
      int rxFill, txFill;
      rxFill = (ph % 2 == 1) ? 9 : 2 + ph;
      txFill = (ph % 4);
      for (int i = 0; i < rxFill; i++) doCycle(1, 16'(ph * 4096 + i * 17 + 1), 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < txFill; i++) doCycle(0, 0, 0, 1, 16'(ph * 4096 + i * 29 + 2), 0, 0, 0);
      if (ph % 3 == 0) doCycle(0, 0, 0, 0, 0, 1, 0, 0);
      checkAll("pre-hold");

      @(posedge clk);
      #(0.3 + 0.45 * ph);
      freezeAsync = 1;
      lat = 0;
      while (!frozen && lat < 6) begin tick(); lat++; end
      chk("R8 hold latency", (lat >= 1 && lat <= 3), 1'b1);

      for (int k = 0; k < 6; k++) begin
        logic [15:0] headBefore;
        headBefore = busRdData;
        doCycle(1, 16'(k * 77 + 5), 1, 1, 16'(k * 99 + 11), 1, 1, 1);
        if (rxQ.size() != 0) chk("R9 head stays during hold", busRdData, headBefore);
        checkAll("R9 R10 hold");
      end

      freezeAsync = 0;
      lat = 0;
      while (frozen && lat < 6) begin tick(); lat++; end
      chk("R8 release latency", (lat >= 1 && lat <= 3), 1'b1);
      checkAll("R11 after release");

      while (rxQ.size() != 0) begin
        chk("R11 rx order", busRdData, rxQ[0]);
        doCycle(0, 0, 1, 0, 0, 0, 1, 0);
        checkAll("R11 rx drain");
      end
      while (txQ.size() != 0) begin
        doCycle(0, 0, 0, 0, 0, 1, 0, 0);
        checkAll("R11 tx drain");
      end
      doCycle(0, 0, 0, 0, 0, 0, 1, 1);
      checkAll("R11 cleared");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule